// File: doc/BRIEF.md
# Overcurrent Blanking and Deglitch Monitor

This block watches one overcurrent comparator flag per power switch for a three-phase bridge of six switches. Switches 0 to 2 are the high-side devices, whose flag reflects the drain-to-phase voltage. Switches 3 to 5 are the low-side devices, whose flag reflects the phase-to-sense voltage.

Each switch has its own filter. A blanking window restarts whenever the switch's gate command goes high, and the comparator is ignored while that window runs. Once blanking has expired, a trip must stay present for a programmable deglitch period before it counts as a detection.

A 2-bit response mode decides what a detection does:

- **Latch shutdown:** the detection forces all six gate outputs low, pulls the active-low fault flag down and sets the switch's bit in a sticky record.
- **Report only:** the detection sets the flag and the record, and the gates keep following their commands.
- **Disabled:** the detection is dropped.

A single-cycle clear pulse empties the record and releases the latched shutdown.

Top module: `ocp_monitor`

## Requirements
- R1: During and immediately after reset, `fault_rec` is 0, `fault_n` is 1 and `shutdown` is 0.
- R2: With `blank_time` = N > 0, the first N clock cycles in which a switch's command is high, counted from the cycle of its rising command, ignore that switch's trip flag.
- R3: With `blank_time` = 0, the trip flag is monitored from the first cycle the command is high.
- R4: A detection on switch i needs the trip to be high in `deglitch_time`+1 consecutive monitored cycles. Any low cycle restarts the count. The detection is reflected in the outputs one clock edge after the cycle that completes the count.
- R5: Mode 00 (latch shutdown): a detection sets `fault_rec[i]`, drives `fault_n` low, sets `shutdown`, and forces `gate_out` to 0 while `shutdown` is 1.
- R6: Mode 01 (report only): a detection sets `fault_rec[i]` and drives `fault_n` low, `shutdown` stays 0, and `gate_out` equals `gate_cmd`.
- R7: Modes 10 and 11 (disabled): trips change neither `fault_rec`, `fault_n` nor `shutdown`.
- R8: `fault_rec` bits and `shutdown` hold until a `fault_clr` cycle clears them. A detection completed in the clear cycle is still recorded, and `fault_n` is low exactly when `fault_rec` is non-zero.
- R9: Driving a command low cancels that switch's blanking and deglitch progress, and a trip while the command is low never leads to a detection.
- R10: `fault_rec` bit i belongs to switch i (bits 0 to 2 high side, bits 3 to 5 low side). Detections on several switches accumulate as a bitwise OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_cmd | input | 6 | Gate commands, 1 = switch on |
| vds_trip | input | 6 | Overcurrent comparator flags, 1 = tripped |
| blank_time | input | 8 | Blanking length in cycles |
| deglitch_time | input | 8 | Extra consecutive trip cycles needed beyond the first |
| mode | input | 2 | Response: 00 latch, 01 report, 10/11 disabled |
| fault_clr | input | 1 | One-cycle pulse clearing the record and the shutdown |
| gate_out | output | 6 | Gate outputs after shutdown masking |
| fault_n | output | 1 | Active-low fault flag (low = fault) |
| fault_rec | output | 6 | Sticky per-switch fault record |
| shutdown | output | 1 | Latched shutdown, forces all gate outputs low |

## Verification
The bench targets the following corner cases, each with the failure a wrong design would show:

- **End of the blanking window.** A trip held through the whole window must not be recorded. An off-by-one design would record the switch one cycle early.
- **Deglitch restart.** A one-cycle gap in the middle of the deglitch count must restart it. A design that only paused the count would record the fault early.
- **Turn-off mid-count.** A command that drops partway through a count must restart it from zero. A design that kept stale progress would fault after too few cycles.
- **Detection in the clear cycle.** A detection completed in the same cycle as `fault_clr` must survive the clear. A design where the clear had priority would lose that switch.
- **Disabled mode and shutdown.** Both disabled codes must be tested, along with the latched gate masking. A decoder that treated 11 as active, or a shutdown that fell once the trips went away, would be caught by the record and gate outputs.

// File: rtl/ocp_pkg.sv
// Package: shared types for the overcurrent monitor.
// Assumes a 2-bit response mode where bit 1 set means disabled.
package ocp_pkg;

    typedef enum logic [1:0] {
        RESP_LATCH  = 2'b00,
        RESP_REPORT = 2'b01,
        RESP_OFF_A  = 2'b10,
        RESP_OFF_B  = 2'b11
    } resp_mode_e;

    // True when the given mode records detections
    function automatic logic mode_records(input logic [1:0] m);
        return (m[1] == 1'b0);
    endfunction

endpackage

// File: rtl/ocp_channel.sv
// Per-switch filter: blanking after each rising command, then a
// consecutive-trip deglitch count. Emits a combinational detect in the
// cycle the deglitch requirement is met.
// Assumes blank_time and deglitch_time are held while the command is high.
module ocp_channel #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd,
    input  logic             trip,
    input  logic [CNT_W-1:0] blank_time,
    input  logic [CNT_W-1:0] deglitch_time,
    output logic             detect
);

    logic             cmd_q;
    logic [CNT_W-1:0] blank_rem;
    logic [CNT_W-1:0] glitch_cnt;
    logic             rise;
    logic             blank_done;
    logic             hit;

    // Decode edge, blanking state, qualified trip and detection
    always_comb begin
        rise       = cmd & ~cmd_q;
        blank_done = rise ? (blank_time == '0) : (blank_rem == '0);
        hit        = cmd & blank_done & trip;
        detect     = hit & (glitch_cnt >= deglitch_time);
    end

    // Remember last command to find its rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_q <= 1'b0;
        else        cmd_q <= cmd;
    end

    // Blanking countdown, restarted by each turn-on, cancelled by turn-off
    always_ff @(posedge clk) begin
        if (!rst_n || !cmd) begin
            blank_rem <= '0;
        end else if (rise) begin
            blank_rem <= (blank_time == '0) ? '0 : blank_time - 1'b1;
        end else if (blank_rem != '0) begin
            blank_rem <= blank_rem - 1'b1;
        end
    end

    // Count consecutive qualified trips, saturating at the deglitch value
    always_ff @(posedge clk) begin
        if (!rst_n || !hit) begin
            glitch_cnt <= '0;
        end else if (glitch_cnt < deglitch_time) begin
            glitch_cnt <= glitch_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/ocp_response.sv
// Fault response: sticky per-switch record and latched shutdown,
// selected by the response mode. Clear empties both but a detection in
// the same cycle is kept.
// Assumes fault_clr is a synchronous pulse.
module ocp_response #(
    parameter int NUM_SW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [NUM_SW-1:0] detect,
    input  logic              fault_clr,
    output logic [NUM_SW-1:0] fault_rec,
    output logic              shutdown
);
    import ocp_pkg::*;

    logic [NUM_SW-1:0] accepted;
    logic              trip_latch;

    // Filter detections by mode
    always_comb begin
        accepted   = mode_records(mode) ? detect : '0;
        trip_latch = (mode == RESP_LATCH) && (detect != '0);
    end

    // Sticky record of which switches faulted
    always_ff @(posedge clk) begin
        if (!rst_n) fault_rec <= '0;
        else        fault_rec <= (fault_clr ? '0 : fault_rec) | accepted;
    end

    // Latched shutdown request
    always_ff @(posedge clk) begin
        if (!rst_n) shutdown <= 1'b0;
        else        shutdown <= (fault_clr ? 1'b0 : shutdown) | trip_latch;
    end

endmodule

// File: rtl/ocp_monitor.sv
// Top: six per-switch filters feeding one response unit, plus gate
// masking while shut down. Fault flag is active low (open-drain style).
// Assumes all inputs are synchronous to clk.
module ocp_monitor #(
    parameter int NUM_SW = 6,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_SW-1:0] gate_cmd,
    input  logic [NUM_SW-1:0] vds_trip,
    input  logic [CNT_W-1:0]  blank_time,
    input  logic [CNT_W-1:0]  deglitch_time,
    input  logic [1:0]        mode,
    input  logic              fault_clr,
    output logic [NUM_SW-1:0] gate_out,
    output logic              fault_n,
    output logic [NUM_SW-1:0] fault_rec,
    output logic              shutdown
);

    logic [NUM_SW-1:0] detect;

    for (genvar i = 0; i < NUM_SW; i++) begin : g_ch
        ocp_channel #(.CNT_W(CNT_W)) u_ch (
            .clk           (clk),
            .rst_n         (rst_n),
            .cmd           (gate_cmd[i]),
            .trip          (vds_trip[i]),
            .blank_time    (blank_time),
            .deglitch_time (deglitch_time),
            .detect        (detect[i])
        );
    end

    ocp_response #(.NUM_SW(NUM_SW)) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .detect    (detect),
        .fault_clr (fault_clr),
        .fault_rec (fault_rec),
        .shutdown  (shutdown)
    );

    // Drive gates and the active-low flag
    always_comb begin
        gate_out = shutdown ? '0 : gate_cmd;
        fault_n  = (fault_rec == '0);
    end

endmodule

// File: rtl/ocp_monitor_chk.sv
// Checker for ocp_monitor, attached by bind. Holds only assertions.
module ocp_monitor_chk #(
    parameter int NUM_SW = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SW-1:0] gate_cmd,
    input logic [1:0]        mode,
    input logic              fault_clr,
    input logic [NUM_SW-1:0] fault_rec,
    input logic              shutdown,
    input logic              fault_n
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fault_rec == '0 && !shutdown && fault_n));

    assert_shutdown_has_record_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |-> (fault_rec != '0));

    assert_report_no_shutdown_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !shutdown) |=> !shutdown);

    assert_disabled_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && !fault_clr) |=> ($stable(fault_rec) && $stable(shutdown)));

    assert_sticky_record_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_clr |=> ((fault_rec & $past(fault_rec)) == $past(fault_rec)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_clr && mode[1]) |=> (fault_rec == '0 && !shutdown));

    assert_off_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cmd == '0 && !fault_clr) |=> $stable(fault_rec));

endmodule

bind ocp_monitor ocp_monitor_chk #(.NUM_SW(NUM_SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate_cmd  (gate_cmd),
    .mode      (mode),
    .fault_clr (fault_clr),
    .fault_rec (fault_rec),
    .shutdown  (shutdown),
    .fault_n   (fault_n)
);

// File: tb/ocp_monitor_tb.sv
module ocp_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] gate_cmd = '0;
    logic [5:0] vds_trip = '0;
    logic [7:0] blank_time = '0;
    logic [7:0] deglitch_time = '0;
    logic [1:0] mode = 2'b01;
    logic       fault_clr = 1'b0;
    logic [5:0] gate_out;
    logic       fault_n;
    logic [5:0] fault_rec;
    logic       shutdown;

    int checks = 0;
    int errors = 0;

    // reference model state
    int   on_cnt [6];
    int   run    [6];
    logic [5:0] m_rec  = '0;
    logic       m_shut = 1'b0;

    always #10 clk = ~clk;

    ocp_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .gate_cmd(gate_cmd), .vds_trip(vds_trip),
        .blank_time(blank_time), .deglitch_time(deglitch_time), .mode(mode),
        .fault_clr(fault_clr), .gate_out(gate_out), .fault_n(fault_n),
        .fault_rec(fault_rec), .shutdown(shutdown)
    );

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        logic [5:0] det;
        det = '0;
        if (!rst_n) begin
            for (int i = 0; i < 6; i++) begin on_cnt[i] = 0; run[i] = 0; end
            m_rec  = '0;
            m_shut = 1'b0;
        end else begin
            for (int i = 0; i < 6; i++) begin
                if (!gate_cmd[i]) begin
                    on_cnt[i] = 0;
                    run[i]    = 0;
                end else begin
                    if (on_cnt[i] < 100000) on_cnt[i] = on_cnt[i] + 1;
                    if (on_cnt[i] > int'(blank_time) && vds_trip[i]) run[i] = run[i] + 1;
                    else run[i] = 0;
                    det[i] = (run[i] > int'(deglitch_time));
                end
            end
            if (fault_clr) begin m_rec = '0; m_shut = 1'b0; end
            if (mode[1] == 1'b0) m_rec = m_rec | det;
            if (mode == 2'b00 && det != '0) m_shut = 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 R6 gate_out", gate_out, m_shut ? 6'b0 : gate_cmd);
            chk("R8 fault_n", {5'b0, fault_n}, {5'b0, (m_rec == '0)});
            chk("R2 R4 R10 fault_rec", fault_rec, m_rec);
            chk("R5 R8 shutdown", {5'b0, shutdown}, {5'b0, m_shut});
        end
    end

    task automatic tick(input int n);
        repeat (n) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic do_clear();
        gate_cmd = '0; vds_trip = '0; fault_clr = 1'b1;
        tick(1);
        fault_clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        chk("R1 reset rec", fault_rec, 6'b0);
        chk("R1 reset flag", {5'b0, fault_n}, 6'b1);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after reset rec", fault_rec, 6'b0);
        chk("R1 after reset shutdown", {5'b0, shutdown}, 6'b0);

        // R2: trip for the whole blanking window is ignored
        mode = 2'b01; blank_time = 8'd4; deglitch_time = 8'd2;
        gate_cmd = 6'b000001; vds_trip = 6'b000001;
        tick(4);
        chk("R2 blanked trip", fault_rec, 6'b0);
        gate_cmd = '0; vds_trip = '0; tick(1);

        // R4: gap restarts the deglitch count
        gate_cmd = 6'b000010; tick(4);
        vds_trip = 6'b000010; tick(2);
        vds_trip = 6'b000000; tick(1);
        vds_trip = 6'b000010; tick(2);
        chk("R4 before count done", fault_rec, 6'b0);
        tick(1);
        chk("R4 detection", fault_rec, 6'b000010);
        chk("R6 flag low", {5'b0, fault_n}, 6'b0);
        chk("R6 gates follow", gate_out, 6'b000010);
        chk("R6 no shutdown", {5'b0, shutdown}, 6'b0);
        do_clear();
        chk("R8 cleared", fault_rec, 6'b0);

        // R9: turn-off cancels deglitch progress; trips while off ignored
        blank_time = 8'd0; deglitch_time = 8'd3;
        gate_cmd = 6'b000100; vds_trip = 6'b000100; tick(3);
        gate_cmd = 6'b000000; tick(5);
        chk("R9 trip while off", fault_rec, 6'b0);
        gate_cmd = 6'b000100; tick(3);
        chk("R9 restarted count", fault_rec, 6'b0);
        tick(1);
        chk("R9 full count", fault_rec, 6'b000100);
        do_clear();

        // R3: zero blanking and zero deglitch, first on cycle counts
        deglitch_time = 8'd0;
        gate_cmd = 6'b001000; vds_trip = 6'b001000; tick(1);
        chk("R3 immediate", fault_rec, 6'b001000);
        do_clear();

        // R5: latch shutdown
        mode = 2'b00; blank_time = 8'd2; deglitch_time = 8'd1;
        gate_cmd = 6'b100001; vds_trip = 6'b100000; tick(3);
        chk("R5 not yet", fault_rec, 6'b0);
        chk("R5 gates pass", gate_out, 6'b100001);
        tick(1);
        chk("R5 record", fault_rec, 6'b100000);
        chk("R5 shutdown", {5'b0, shutdown}, 6'b1);
        chk("R5 gates forced low", gate_out, 6'b0);
        gate_cmd = '0; vds_trip = '0; tick(5);
        chk("R8 sticky record", fault_rec, 6'b100000);
        chk("R8 sticky shutdown", {5'b0, shutdown}, 6'b1);

        // R8: detection in the clear cycle survives
        mode = 2'b01; blank_time = 8'd0; deglitch_time = 8'd0;
        gate_cmd = 6'b010000; vds_trip = 6'b010000; fault_clr = 1'b1; tick(1);
        fault_clr = 1'b0;
        chk("R8 clear-cycle detection", fault_rec, 6'b010000);
        chk("R8 shutdown released", {5'b0, shutdown}, 6'b0);
        do_clear();

        // R7: both disabled codes
        mode = 2'b10; gate_cmd = 6'h3F; vds_trip = 6'h3F; tick(5);
        chk("R7 mode 10 record", fault_rec, 6'b0);
        mode = 2'b11; tick(5);
        chk("R7 mode 11 record", fault_rec, 6'b0);
        chk("R7 flag high", {5'b0, fault_n}, 6'b1);
        chk("R7 gates follow", gate_out, 6'h3F);
        gate_cmd = '0; vds_trip = '0; tick(1);

        // R10: bit positions and accumulation
        mode = 2'b01; gate_cmd = 6'h3F; vds_trip = 6'b000101; tick(1);
        chk("R10 two bits", fault_rec, 6'b000101);
        vds_trip = 6'b001000; tick(1);
        chk("R10 accumulate", fault_rec, 6'b001101);
        do_clear();

        // randomized segments checked against the model every cycle
        for (int seg = 0; seg < 8; seg++) begin
            gate_cmd = '0; vds_trip = '0; tick(1);
            blank_time    = 8'($urandom_range(0, 5));
            deglitch_time = 8'($urandom_range(0, 3));
            mode          = 2'($urandom_range(0, 3));
            for (int c = 0; c < 400; c++) begin
                if ($urandom_range(0, 5) == 0) gate_cmd[$urandom_range(0, 5)] ^= 1'b1;
                vds_trip  = 6'($urandom | $urandom);
                fault_clr = ($urandom_range(0, 30) == 0);
                if ($urandom_range(0, 100) == 0) mode = 2'($urandom_range(0, 3));
                tick(1);
            end
            fault_clr = 1'b0;
        end

        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule